// File: doc/BRIEF.md
# Static-Route Mesh Switch with Multicast

This block is the switching element at one node of a two-dimensional mesh. It has five ports: four that lead to the neighbouring nodes (north, east, south, west) and one that leads to the compute core at the node. Every port carries 32-bit flits in each direction. The upper half of a flit is control and the lower half is a 16-bit data value. Five bits of the control half name one of a fixed number of routes, which is 24 by default. Routes are never computed from addresses. Instead, a table that is loaded ahead of time gives, for each pair of input port and route, the set of output ports that receive a copy. One flit can therefore go to one neighbour, to several (multicast), or to every port (broadcast). All copies leave in the same cycle.

Many routes share each physical output. For each route, every output keeps a credit counter sized for a two-entry buffer at the receiver. A route that has run out of credits stalls only its own traffic. Other routes on the same wire keep moving. When several inputs want the same output, a rotating priority picks one. Losing inputs keep their flit and offer it again. A flit that passes through the switch leaves on the output registers one clock after it was accepted.

Top module: `mesh_route_switch`

## Requirements
- R1: While reset is asserted and after reset, `out_vld` is 0, `drop_err` is 0, every output holds 2 credits for every route, and every table entry is an empty mask. A flit offered on a route that has not been configured is therefore accepted and goes nowhere.
- R2: Flit layout: bits [15:0] are data, bits [31:16] are control, and the route number is bits [20:16]. A flit on a configured route is accepted in the cycle in which `in_rdy` is high for its port. It appears unchanged on every selected output, with `out_vld` high, one clock later.
- R3: Port index encoding is north=0, east=1, south=2, west=3, core=4. Output port o receives a copy when bit o of the mask is set. All copies of one flit appear in the same cycle.
- R4: A flit whose route number is 24 to 31 is accepted at once (`in_rdy` high) and produces no output. `drop_err` is high in the next cycle only, unless another such flit arrives.
- R5: A flit whose mask is empty is accepted and produces no output and no error.
- R6: Each output holds at most 2 credits per route, and sending one copy uses one credit. A flit waits, with `in_rdy` low, while any output in its mask has no credit left for its route. It is then sent in full later and never in part.
- R7: A pulse on `crd_ret_vld[o]` with route `crd_ret_rid[o*5 +: 5]` gives that output one credit back for that route. A return that would take the count above 2 is ignored.
- R8: A route that has used up its credits on an output does not block a different route from reaching the same output.
- R9: Each output takes at most one flit per cycle. Contending inputs are served in rotating order, so two inputs that keep competing for one output win on alternate cycles. A losing input sees `in_rdy` low and keeps its flit.
- R10: A write with `cfg_we` high sets the mask of entry (`cfg_port`, `cfg_rid`) to `cfg_mask` at the clock edge. Flits accepted after that edge use the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 5 | Flit offered on each input port |
| in_flit | input | 160 | Input flits, port p at bits [p*32 +: 32] |
| in_rdy | output | 5 | Flit taken on each input port this cycle |
| out_vld | output | 5 | Flit present on each output port |
| out_flit | output | 160 | Output flits, port o at bits [o*32 +: 32] |
| crd_ret_vld | input | 5 | Credit returned to each output port |
| crd_ret_rid | input | 25 | Route of the returned credit, port o at bits [o*5 +: 5] |
| cfg_we | input | 1 | Route table write strobe |
| cfg_port | input | 3 | Input port of the entry being written |
| cfg_rid | input | 5 | Route of the entry being written |
| cfg_mask | input | 5 | Output mask written into the entry |
| drop_err | output | 1 | Pulse one cycle after a flit with an out-of-range route |

## Verification
`in_rdy` is combinational, so it is sampled a moment after the inputs change on the falling edge and before the next rising edge. Output copies and `drop_err` are registered once and are sampled at the falling edge that follows the accepting rising edge. Credit returns and table writes take effect at the rising edge where they are presented. Their effect on `in_rdy` is therefore checked at the falling edge after that. The bench keeps its own count of each route's credits so it knows exactly which offer must stall, and the bound checker keeps a count of its own, built from the ports alone.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int NPORT          = 5;
  localparam int FLIT_W         = 32;
  localparam int RID_LSB        = 16;
  localparam int RID_W          = 5;
  localparam int PIDX_W         = 3;
  localparam int ROUTES         = 24;
  localparam int CRED_PER_ROUTE = 2;

  typedef enum logic [PIDX_W-1:0] {
    PORT_N = 3'd0,
    PORT_E = 3'd1,
    PORT_S = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_e;
endpackage

// File: rtl/mrs_reset_sync.sv
module mrs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/mrs_route_table.sv
module mrs_route_table import mrs_pkg::*; #(
  parameter int NP     = NPORT,
  parameter int NROUTE = ROUTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [PIDX_W-1:0]           wr_port,
  input  logic [RID_W-1:0]            wr_rid,
  input  logic [NP-1:0]               wr_mask,
  input  logic [NP-1:0][RID_W-1:0]    rd_rid,
  output logic [NP-1:0][NP-1:0]       rd_mask
);
  localparam logic [RID_W-1:0]  RLIM = RID_W'(NROUTE);
  localparam logic [PIDX_W-1:0] PLIM = PIDX_W'(NP);

  logic [NP-1:0] tbl_q [NROUTE][NP];
  logic          wr_ok;

  assign wr_ok = wr_en && (wr_rid < RLIM) && (wr_port < PLIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROUTE; r++)
        for (int p = 0; p < NP; p++)
          tbl_q[r][p] <= '0;
    end else if (wr_ok) begin
      tbl_q[wr_rid][wr_port] <= wr_mask;
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rd_mask[p] = '0;
      if (rd_rid[p] < RLIM) rd_mask[p] = tbl_q[rd_rid[p]][p];
    end
  end
endmodule

// File: rtl/mrs_credit_bank.sv
module mrs_credit_bank import mrs_pkg::*; #(
  parameter int NROUTE   = ROUTES,
  parameter int CRED_MAX = CRED_PER_ROUTE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [RID_W-1:0]  take_rid,
  input  logic              ret,
  input  logic [RID_W-1:0]  ret_rid,
  output logic [NROUTE-1:0] has_cred
);
  localparam int            CW   = $clog2(CRED_MAX + 1);
  localparam logic [CW-1:0] CMAX = CW'(CRED_MAX);

  logic [CW-1:0] cnt_q [NROUTE];
  logic [CW-1:0] cnt_d [NROUTE];

  always_comb begin
    for (int r = 0; r < NROUTE; r++) begin
      logic inc, dec;
      inc = ret && (ret_rid == RID_W'(r)) && (cnt_q[r] < CMAX);
      dec = take && (take_rid == RID_W'(r));
      cnt_d[r] = cnt_q[r];
      if (inc && !dec)      cnt_d[r] = cnt_q[r] + CW'(1);
      else if (dec && !inc) cnt_d[r] = cnt_q[r] - CW'(1);
      has_cred[r] = (cnt_q[r] != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROUTE; r++) cnt_q[r] <= CMAX;
    end else begin
      for (int r = 0; r < NROUTE; r++) cnt_q[r] <= cnt_d[r];
    end
  end
endmodule

// File: rtl/mrs_rr_select.sv
module mrs_rr_select #(
  parameter int N  = 5,
  parameter int PW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);
  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesh_route_switch.sv
module mesh_route_switch import mrs_pkg::*; #(
  parameter int NROUTE   = ROUTES,
  parameter int CRED_MAX = CRED_PER_ROUTE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          in_vld,
  input  logic [NPORT*FLIT_W-1:0]   in_flit,
  output logic [NPORT-1:0]          in_rdy,
  output logic [NPORT-1:0]          out_vld,
  output logic [NPORT*FLIT_W-1:0]   out_flit,
  input  logic [NPORT-1:0]          crd_ret_vld,
  input  logic [NPORT*RID_W-1:0]    crd_ret_rid,
  input  logic                      cfg_we,
  input  logic [PIDX_W-1:0]         cfg_port,
  input  logic [RID_W-1:0]          cfg_rid,
  input  logic [NPORT-1:0]          cfg_mask,
  output logic                      drop_err
);
  localparam int               NP   = NPORT;
  localparam int               FW   = FLIT_W;
  localparam int               PW   = $clog2(NP);
  localparam logic [RID_W-1:0] RLIM = RID_W'(NROUTE);

  logic                       rst_n_s;
  logic [NP-1:0][RID_W-1:0]   rid;
  logic [NP-1:0]              bad, zmask, cred_ok, req, fire, top_gnt;
  logic [NP-1:0][NP-1:0]      mask;      // [input][output]
  logic [NP-1:0][NP-1:0]      oreq, gnt; // [output][input]
  logic [NP-1:0][NROUTE-1:0]  has_cred;  // [output][route]
  logic [NP-1:0][RID_W-1:0]   take_rid;
  logic [PW-1:0]              ptr_q, ptr_d;
  logic [NP-1:0]              ovld_d, ovld_q;
  logic [NP-1:0][FW-1:0]      oflit_d, oflit_q;
  logic                       drop_d, drop_q;

  mrs_reset_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  // Route field decode per input port
  for (genvar p = 0; p < NP; p++) begin : g_dec
    assign rid[p]   = in_flit[p*FW+RID_LSB +: RID_W];
    assign bad[p]   = (rid[p] >= RLIM);
    assign zmask[p] = (mask[p] == '0);
  end

  mrs_route_table #(.NP(NP), .NROUTE(NROUTE)) u_tbl (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(cfg_we), .wr_port(cfg_port), .wr_rid(cfg_rid), .wr_mask(cfg_mask),
    .rd_rid(rid), .rd_mask(mask)
  );

  // Credit availability on every masked output
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      cred_ok[p] = 1'b1;
      for (int o = 0; o < NP; o++)
        if (mask[p][o] && !bad[p] && !has_cred[o][rid[p]]) cred_ok[p] = 1'b0;
      req[p] = in_vld[p] && !bad[p] && !zmask[p] && cred_ok[p];
      for (int o = 0; o < NP; o++) oreq[o][p] = req[p] && mask[p][o];
    end
  end

  // One arbiter per output, all sharing the same priority pointer
  for (genvar o = 0; o < NP; o++) begin : g_arb
    mrs_rr_select #(.N(NP), .PW(PW)) u_sel (
      .req(oreq[o]), .ptr(ptr_q), .gnt(gnt[o])
    );
  end

  mrs_rr_select #(.N(NP), .PW(PW)) u_top (.req(req), .ptr(ptr_q), .gnt(top_gnt));

  // An input moves only when it holds the grant of every output in its mask
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      fire[p] = req[p];
      for (int o = 0; o < NP; o++)
        if (mask[p][o] && !gnt[o][p]) fire[p] = 1'b0;
      in_rdy[p] = fire[p] || (in_vld[p] && (bad[p] || zmask[p]));
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      ovld_d[o]   = 1'b0;
      oflit_d[o]  = '0;
      take_rid[o] = '0;
      for (int p = 0; p < NP; p++) begin
        if (gnt[o][p] && fire[p]) begin
          ovld_d[o]   = 1'b1;
          oflit_d[o]  = in_flit[p*FW +: FW];
          take_rid[o] = rid[p];
        end
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int p = 0; p < NP; p++)
      if (top_gnt[p]) ptr_d = (p == NP-1) ? '0 : PW'(p + 1);
    drop_d = |(in_vld & bad);
  end

  for (genvar o = 0; o < NP; o++) begin : g_crd
    mrs_credit_bank #(.NROUTE(NROUTE), .CRED_MAX(CRED_MAX)) u_bank (
      .clk(clk), .rst_n(rst_n_s),
      .take(ovld_d[o]), .take_rid(take_rid[o]),
      .ret(crd_ret_vld[o]), .ret_rid(crd_ret_rid[o*RID_W +: RID_W]),
      .has_cred(has_cred[o])
    );
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovld_q  <= '0;
      oflit_q <= '0;
      ptr_q   <= '0;
      drop_q  <= 1'b0;
    end else begin
      ovld_q <= ovld_d;
      ptr_q  <= ptr_d;
      drop_q <= drop_d;
      for (int o = 0; o < NP; o++)
        if (ovld_d[o]) oflit_q[o] <= oflit_d[o];
    end
  end

  assign out_vld  = ovld_q;
  assign out_flit = oflit_q;
  assign drop_err = drop_q;
endmodule

// File: rtl/mesh_route_switch_chk.sv
module mesh_route_switch_chk import mrs_pkg::*; #(
  parameter int NROUTE   = ROUTES,
  parameter int CRED_MAX = CRED_PER_ROUTE
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        in_vld,
  input logic [NPORT*FLIT_W-1:0] in_flit,
  input logic [NPORT-1:0]        in_rdy,
  input logic [NPORT-1:0]        out_vld,
  input logic [NPORT*FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0]        crd_ret_vld,
  input logic [NPORT*RID_W-1:0]  crd_ret_rid,
  input logic                    drop_err
);
  localparam int               NP   = NPORT;
  localparam int               CW   = $clog2(CRED_MAX + 1);
  localparam logic [CW-1:0]    CMAX = CW'(CRED_MAX);
  localparam logic [RID_W-1:0] RLIM = RID_W'(NROUTE);

  logic [NP-1:0] bad_in, cred_seen;
  logic [CW-1:0] sh_q [NP][NROUTE];

  for (genvar p = 0; p < NP; p++) begin : g_bad
    assign bad_in[p] = (in_flit[p*FLIT_W+RID_LSB +: RID_W] >= RLIM);
  end

  // Credit shadow built only from port activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NP; o++)
        for (int r = 0; r < NROUTE; r++) sh_q[o][r] <= CMAX;
    end else begin
      for (int o = 0; o < NP; o++)
        for (int r = 0; r < NROUTE; r++) begin
          logic dec, inc;
          dec = out_vld[o] && (out_flit[o*FLIT_W+RID_LSB +: RID_W] == RID_W'(r));
          inc = crd_ret_vld[o] && (crd_ret_rid[o*RID_W +: RID_W] == RID_W'(r));
          if (inc && !dec && sh_q[o][r] < CMAX) sh_q[o][r] <= sh_q[o][r] + CW'(1);
          else if (dec && !inc)                  sh_q[o][r] <= sh_q[o][r] - CW'(1);
        end
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      logic [RID_W-1:0] orid;
      orid = out_flit[o*FLIT_W+RID_LSB +: RID_W];
      cred_seen[o] = (orid < RLIM) ? (sh_q[o][orid] != '0) : 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (out_vld == '0) && !drop_err);

  assert_out_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_vld) |-> $past(|(in_vld & in_rdy & ~bad_in)));

  assert_drop_follows_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_vld & bad_in)) |=> drop_err);

  assert_drop_only_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(in_vld & bad_in)) |=> !drop_err);

  assert_bad_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_vld & bad_in & ~in_rdy) == '0));

  assert_rdy_needs_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_rdy & ~in_vld) == '0));

  for (genvar o = 0; o < NP; o++) begin : g_cred
    assert_credit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[o] |-> cred_seen[o]);
  end
endmodule

bind mesh_route_switch mesh_route_switch_chk #(.NROUTE(NROUTE), .CRED_MAX(CRED_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit), .in_rdy(in_rdy),
  .out_vld(out_vld), .out_flit(out_flit), .crd_ret_vld(crd_ret_vld),
  .crd_ret_rid(crd_ret_rid), .drop_err(drop_err)
);

// File: tb/mesh_route_switch_tb_top.sv
module mesh_route_switch_tb_top;
  localparam int PN = 0, PE = 1, PS = 2, PWS = 3, PL = 4;

  logic         clk, rst_n;
  logic [4:0]   in_vld, in_rdy, out_vld, crd_ret_vld, cfg_mask;
  logic [159:0] in_flit, out_flit;
  logic [24:0]  crd_ret_rid;
  logic         cfg_we, drop_err;
  logic [2:0]   cfg_port;
  logic [4:0]   cfg_rid;

  int total = 0;
  int bad   = 0;

  mesh_route_switch dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_flit(out_flit), .crd_ret_vld(crd_ret_vld),
    .crd_ret_rid(crd_ret_rid), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_rid(cfg_rid), .cfg_mask(cfg_mask), .drop_err(drop_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [2:0]  src;
    logic [4:0]  rid;
    logic [15:0] data;
    logic [4:0]  emask;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{3'd3, 5'd1,  16'h1111, 5'b00010},
    '{3'd0, 5'd2,  16'h2222, 5'b10100},
    '{3'd4, 5'd3,  16'h3333, 5'b01111},
    '{3'd1, 5'd4,  16'h4444, 5'b11111},
    '{3'd2, 5'd23, 16'h5555, 5'b01000},
    '{3'd4, 5'd0,  16'h6666, 5'b00001},
    '{3'd0, 5'd5,  16'h7777, 5'b00000}
  };

  function automatic logic [31:0] mk(input logic [4:0] rid, input logic [15:0] d);
    return {11'h2A5, rid, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [159:0] act,
                     input logic [159:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic put(input int p, input logic [4:0] rid, input logic [15:0] d);
    in_vld[p] = 1'b1;
    in_flit[p*32 +: 32] = mk(rid, d);
  endtask

  task automatic cfg(input int p, input logic [4:0] rid, input logic [4:0] m);
    cfg_we = 1'b1; cfg_port = 3'(p); cfg_rid = rid; cfg_mask = m;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ret(input logic [4:0] m, input logic [4:0] rid);
    crd_ret_vld = m;
    crd_ret_rid = {5{rid}};
    @(posedge clk); @(negedge clk);
    crd_ret_vld = '0;
  endtask

  // Offer one flit that must be taken; check its copies one clock later
  task automatic hop(input int p, input logic [4:0] rid, input logic [15:0] d,
                     input logic [4:0] em, input string tag);
    put(p, rid, d);
    #1;
    chk(in_rdy[p] == 1'b1, tag, 160'(in_rdy), 160'(5'b1 << p));
    @(posedge clk); @(negedge clk);
    chk(out_vld == em, tag, 160'(out_vld), 160'(em));
    chk(drop_err == 1'b0, tag, 160'(drop_err), 160'(0));
    for (int o = 0; o < 5; o++)
      if (em[o]) chk(out_flit[o*32 +: 32] == mk(rid, d), tag,
                     160'(out_flit[o*32 +: 32]), 160'(mk(rid, d)));
    in_vld[p] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    in_vld = '0; in_flit = '0; crd_ret_vld = '0; crd_ret_rid = '0;
    cfg_we = 1'b0; cfg_port = '0; cfg_rid = '0; cfg_mask = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld == '0 && drop_err == 1'b0, "R1 in reset", 160'(out_vld), 160'(0));
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_vld == '0 && drop_err == 1'b0, "R1 after reset", 160'(out_vld), 160'(0));
    // Empty table after reset: taken, sent nowhere
    hop(PWS, 5'd1, 16'hAAAA, 5'b00000, "R1 empty table");

    // Load the table for the vector walk (R10)
    for (int i = 0; i < 7; i++)
      if (VEC[i].emask != '0) cfg(int'(VEC[i].src), VEC[i].rid, VEC[i].emask);

    // Vector walk: R2 R3 R5, credits returned after each hop
    for (int i = 0; i < 7; i++) begin
      hop(int'(VEC[i].src), VEC[i].rid, VEC[i].data, VEC[i].emask,
          (VEC[i].emask == '0) ? "R5 empty mask" : "R2 R3 vector");
      if (VEC[i].emask != '0) ret(VEC[i].emask, VEC[i].rid);
    end

    // R10: rewrite an entry, next flit follows the new mask
    cfg(PWS, 5'd1, 5'b10000);
    hop(PWS, 5'd1, 16'hB0B0, 5'b10000, "R10 new mask");
    ret(5'b10000, 5'd1);
    cfg(PWS, 5'd1, 5'b00010);

    // R4: out-of-range routes
    put(PN, 5'd24, 16'hDEAD);
    #1 chk(in_rdy[PN] == 1'b1, "R4 rid24 taken", 160'(in_rdy), 160'(1));
    @(posedge clk); @(negedge clk);
    chk(drop_err == 1'b1, "R4 err pulse", 160'(drop_err), 160'(1));
    chk(out_vld == '0, "R4 no output", 160'(out_vld), 160'(0));
    in_vld[PN] = 1'b0;
    put(PS, 5'd31, 16'hBEEF);
    @(posedge clk); @(negedge clk);
    chk(drop_err == 1'b1, "R4 rid31 err", 160'(drop_err), 160'(1));
    in_vld[PS] = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(drop_err == 1'b0, "R4 err one cycle", 160'(drop_err), 160'(0));

    // R6: multicast N route 2 -> S|L stalls until both outputs have a credit
    hop(PN, 5'd2, 16'h0001, 5'b10100, "R6 first");
    hop(PN, 5'd2, 16'h0002, 5'b10100, "R6 second");
    put(PN, 5'd2, 16'h0003);
    #1 chk(in_rdy[PN] == 1'b0, "R6 held no credit", 160'(in_rdy[PN]), 160'(0));
    @(posedge clk); @(negedge clk);
    chk(out_vld == '0, "R6 nothing sent", 160'(out_vld), 160'(0));
    crd_ret_vld = 5'b00100; crd_ret_rid = {5{5'd2}};
    @(posedge clk); @(negedge clk);
    crd_ret_vld = 5'b10000;
    #1 chk(in_rdy[PN] == 1'b0, "R6 partial credit held", 160'(in_rdy[PN]), 160'(0));
    chk(out_vld == '0, "R6 no partial copy", 160'(out_vld), 160'(0));
    @(posedge clk); @(negedge clk);
    crd_ret_vld = '0;
    #1 chk(in_rdy[PN] == 1'b1, "R7 return unblocks", 160'(in_rdy[PN]), 160'(1));
    @(posedge clk); @(negedge clk);
    chk(out_vld == 5'b10100, "R6 whole multicast", 160'(out_vld), 160'(5'b10100));
    chk(out_flit[PL*32 +: 32] == mk(5'd2, 16'h0003), "R6 flit",
        160'(out_flit[PL*32 +: 32]), 160'(mk(5'd2, 16'h0003)));
    in_vld[PN] = 1'b0;
    ret(5'b10100, 5'd2);
    ret(5'b10100, 5'd2);

    // R8: route 0 exhausted on N, route 6 from E still reaches N
    cfg(PE, 5'd6, 5'b00001);
    hop(PL, 5'd0, 16'h0A01, 5'b00001, "R8 fill a");
    hop(PL, 5'd0, 16'h0A02, 5'b00001, "R8 fill b");
    put(PL, 5'd0, 16'h0A03);
    put(PE, 5'd6, 16'h0B01);
    #1 chk(in_rdy[PL] == 1'b0 && in_rdy[PE] == 1'b1, "R8 other route passes",
           160'(in_rdy), 160'(5'b00010));
    @(posedge clk); @(negedge clk);
    chk(out_vld == 5'b00001 && out_flit[31:0] == mk(5'd6, 16'h0B01), "R8 output",
        160'(out_flit[31:0]), 160'(mk(5'd6, 16'h0B01)));
    in_vld = '0;
    ret(5'b00001, 5'd6);
    ret(5'b00001, 5'd0);
    ret(5'b00001, 5'd0);

    // R7: a return when full is ignored, so the third flit still waits
    ret(5'b00001, 5'd0);
    hop(PL, 5'd0, 16'h0C01, 5'b00001, "R7 sat a");
    hop(PL, 5'd0, 16'h0C02, 5'b00001, "R7 sat b");
    put(PL, 5'd0, 16'h0C03);
    #1 chk(in_rdy[PL] == 1'b0, "R7 saturation", 160'(in_rdy[PL]), 160'(0));
    in_vld[PL] = 1'b0;
    ret(5'b00001, 5'd0);
    ret(5'b00001, 5'd0);

    // R9: E route 10 and W route 11 both to core, alternate winners
    cfg(PE, 5'd10, 5'b10000);
    cfg(PWS, 5'd11, 5'b10000);
    begin
      int prev;
      logic [15:0] de, dw;
      logic [31:0] wflit;
      prev = -1; de = 16'hE000; dw = 16'hF000;
      put(PE, 5'd10, de);
      put(PWS, 5'd11, dw);
      for (int k = 0; k < 4; k++) begin
        int win;
        #1;
        chk($countones(in_rdy) == 1, "R9 one grant", 160'(in_rdy), 160'(1));
        win = in_rdy[PE] ? PE : PWS;
        if (prev >= 0) chk(win != prev, "R9 alternation", 160'(win), 160'(prev == PE ? PWS : PE));
        wflit = (win == PE) ? mk(5'd10, de) : mk(5'd11, dw);
        prev = win;
        @(posedge clk); @(negedge clk);
        chk(out_vld == 5'b10000 && out_flit[PL*32 +: 32] == wflit, "R9 winner out",
            160'(out_flit[PL*32 +: 32]), 160'(wflit));
        if (win == PE) begin de = de + 16'd1; put(PE, 5'd10, de); end
        else begin dw = dw + 16'd1; put(PWS, 5'd11, dw); end
      end
      in_vld = '0;
    end
    ret(5'b10000, 5'd10);
    ret(5'b10000, 5'd10);
    ret(5'b10000, 5'd11);
    ret(5'b10000, 5'd11);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule